// File: doc/BRIEF.md
# Priority-ordered circular process queue engine

This engine relocates one process control block from one memory-resident queue to another. Each queue lives in a single memory word that holds the index of its tail. The blocks on a queue form a circular, singly linked ring through their link words, so the tail's successor is the head. The engine reaches memory through a word-addressed read/write port with a request/acknowledge handshake. A block's word address is four times its index, so an index field can be used directly as an address.

A command gives three things: the source queue address (or a flag saying the source is unknown), the destination queue address and the process index. The engine first unlinks the process from its ring by finding its predecessor. It then fixes the source tail, or, when the source is unknown, records a cleanup link in the process's flags word. Last, it splices the process into the destination ring. The destination ring is kept in descending priority order, and equal priorities stay in arrival order. A one-cycle done pulse marks the end of the command.

Top module: `proc_q_engine`

## Requirements
- R1: A command is taken only when `busy_o` is low and `cmd_valid_i` is high. `busy_o` stays high from the next cycle until the cycle of `done_o`. A command offered while busy has no effect.
- R2: `done_o` is high for exactly one cycle, in the cycle after the command's last acknowledged memory write.
- R3: A memory request holds `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until `mem_ack_i`. Read data is taken in the acknowledge cycle.
- R4: No memory request is raised while idle or while `done_o` is high.
- R5: If the process's next index equals its own index, then with a known source the source tail becomes 0 (empty).
- R6: Otherwise the predecessor is found by following next links, starting at the source tail, or at the process itself when the source is unknown. The predecessor's next field is then set to the process's next index.
- R7: With a known source whose tail equals the process, the tail becomes the predecessor, or 0 if there is none. Any other source tail is left unchanged.
- R8: With an unknown source, the flags word at address 4×index+1 gets the process's next index in its cleanup field, bits 11:2.
- R9: An empty destination (tail 0) gets tail = process, and the process's next is set to itself.
- R10: If the process priority is less than or equal to the destination tail's priority, the process is linked after the tail and becomes the new tail.
- R11: Otherwise the process is inserted after the last entry whose priority is greater than or equal to its own, walking from the head. The tail is unchanged, and equal priorities keep FIFO order.
- R12: A link word has priority in bits 14:12 and the next index in bits 11:2. Queue words and flags words keep their index field in bits 11:2. Every write changes only its index field and keeps all other bits (such as link bits 15 and 0) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_src_null_i | input | 1 | Source queue unknown |
| cmd_src_addr_i | input | AW | Source queue word address |
| cmd_dst_addr_i | input | AW | Destination queue word address |
| cmd_psb_idx_i | input | 10 | Index of the process to move |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |

## Verification
The bound checker watches the command and memory handshakes on every cycle. It checks that the request is held stable until acknowledged, that there is no traffic while idle, that busy follows acceptance, and that done is a single pulse right after a write. The list surgery itself (predecessor search, tail repair, cleanup link, empty, append and ordered insertion, and bit preservation) can only be seen by the bench's scenarios, which read the queue rings back from the bench memory. One scenario adds wait states to the memory so that the engine must hold its requests.

// File: rtl/proc_q_pkg.sv
package proc_q_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned IDX_LSB  = 2;
  localparam int unsigned IDX_MSB  = 11;
  localparam int unsigned PRIO_LSB = 12;
  localparam int unsigned PRIO_MSB = 14;
  localparam int unsigned IDX_W    = IDX_MSB - IDX_LSB + 1;
  localparam int unsigned PRIO_W   = PRIO_MSB - PRIO_LSB + 1;

  localparam logic [WORD_W-1:0] IDX_MASK =
    WORD_W'(((1 << IDX_W) - 1) << IDX_LSB);

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_RD_LINK,
    ST_RD_SRCQ,
    ST_WALK,
    ST_WR_PREV,
    ST_RD_SRC2,
    ST_WR_SRC,
    ST_RD_FLAGS,
    ST_WR_FLAGS,
    ST_RD_DST,
    ST_WR_DST,
    ST_RD_TAIL,
    ST_RD_NEXT,
    ST_WR_CUR,
    ST_WR_PSB,
    ST_DONE
  } state_e;
endpackage

// File: rtl/proc_q_prio_cmp.sv
module proc_q_prio_cmp
  import proc_q_pkg::*;
(
  input  logic [WORD_W-1:0] a_word_i,
  input  logic [WORD_W-1:0] b_word_i,
  output logic              a_ge_b_o
);
  logic [PRIO_W-1:0] a_prio, b_prio;

  assign a_prio   = a_word_i[PRIO_MSB:PRIO_LSB];
  assign b_prio   = b_word_i[PRIO_MSB:PRIO_LSB];
  assign a_ge_b_o = (a_prio >= b_prio);
endmodule

// File: rtl/proc_q_field_merge.sv
module proc_q_field_merge #(
  parameter int unsigned                W    = 16,
  parameter logic [W-1:0]               MASK = '0
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] field_i,
  output logic [W-1:0] merged_o
);
  // field_i is already positioned; only MASK bits are replaced
  assign merged_o = (base_i & ~MASK) | (field_i & MASK);
endmodule

// File: rtl/proc_q_engine.sv
module proc_q_engine
  import proc_q_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_src_null_i,
  input  logic [AW-1:0]     cmd_src_addr_i,
  input  logic [AW-1:0]     cmd_dst_addr_i,
  input  logic [IDX_W-1:0]  cmd_psb_idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  state_e state_q;

  logic [AW-1:0]     psb_q, src_q, dst_q, cur_q, prev_q, succ_q;
  logic              src_null_q, dst_empty_q;
  logic [WORD_W-1:0] link_q, cl_q, word_q;

  logic [AW-1:0]     rd_idx, link_next, cl_next;
  logic [WORD_W-1:0] mg_base, mg_field, mg_out;
  logic              rd_ge_psb;
  logic              fire;

  assign rd_idx    = AW'(mem_rdata_i & IDX_MASK);
  assign link_next = AW'(link_q & IDX_MASK);
  assign cl_next   = AW'(cl_q & IDX_MASK);
  assign fire      = mem_req_o && mem_ack_i;

  // priority of the word just read versus the moving process
  proc_q_prio_cmp u_prio_cmp (
    .a_word_i (mem_rdata_i),
    .b_word_i (link_q),
    .a_ge_b_o (rd_ge_psb)
  );

  proc_q_field_merge #(
    .W    (WORD_W),
    .MASK (IDX_MASK)
  ) u_merge (
    .base_i   (mg_base),
    .field_i  (mg_field),
    .merged_o (mg_out)
  );

  always_comb begin
    mem_req_o = 1'b1;
    mem_we_o  = 1'b0;
    mem_addr_o = psb_q;
    mg_base   = link_q;
    mg_field  = WORD_W'(succ_q);
    unique case (state_q)
      ST_IDLE, ST_DONE: mem_req_o = 1'b0;
      ST_RD_LINK:  mem_addr_o = psb_q;
      ST_RD_SRCQ:  mem_addr_o = src_q;
      ST_WALK:     mem_addr_o = cur_q;
      ST_WR_PREV: begin
        mem_we_o = 1'b1; mem_addr_o = cur_q;
        mg_base = cl_q; mg_field = WORD_W'(link_next);
      end
      ST_RD_SRC2:  mem_addr_o = src_q;
      ST_WR_SRC: begin
        mem_we_o = 1'b1; mem_addr_o = src_q;
        mg_base = word_q; mg_field = WORD_W'(prev_q);
      end
      ST_RD_FLAGS: mem_addr_o = psb_q | AW'(1);
      ST_WR_FLAGS: begin
        mem_we_o = 1'b1; mem_addr_o = psb_q | AW'(1);
        mg_base = word_q; mg_field = WORD_W'(link_next);
      end
      ST_RD_DST:   mem_addr_o = dst_q;
      ST_WR_DST: begin
        mem_we_o = 1'b1; mem_addr_o = dst_q;
        mg_base = word_q; mg_field = WORD_W'(psb_q);
      end
      ST_RD_TAIL:  mem_addr_o = cur_q;
      ST_RD_NEXT:  mem_addr_o = cl_next;
      ST_WR_CUR: begin
        mem_we_o = 1'b1; mem_addr_o = cur_q;
        mg_base = cl_q; mg_field = WORD_W'(psb_q);
      end
      ST_WR_PSB: begin
        mem_we_o = 1'b1; mem_addr_o = psb_q;
        mg_base = link_q; mg_field = WORD_W'(succ_q);
      end
      default: mem_req_o = 1'b0;
    endcase
  end

  assign mem_wdata_o = mem_we_o ? mg_out : '0;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      psb_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      cur_q       <= '0;
      prev_q      <= '0;
      succ_q      <= '0;
      src_null_q  <= 1'b0;
      dst_empty_q <= 1'b0;
      link_q      <= '0;
      cl_q        <= '0;
      word_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          psb_q      <= AW'({cmd_psb_idx_i, 2'b00});
          src_q      <= cmd_src_addr_i;
          dst_q      <= cmd_dst_addr_i;
          src_null_q <= cmd_src_null_i;
          state_q    <= ST_RD_LINK;
        end
        ST_RD_LINK: if (fire) begin
          link_q <= mem_rdata_i;
          if (rd_idx == psb_q) begin
            prev_q  <= '0;
            state_q <= src_null_q ? ST_RD_FLAGS : ST_RD_SRC2;
          end else if (src_null_q) begin
            cur_q   <= psb_q;
            state_q <= ST_WALK;
          end else begin
            state_q <= ST_RD_SRCQ;
          end
        end
        ST_RD_SRCQ: if (fire) begin
          cur_q   <= rd_idx;
          state_q <= ST_WALK;
        end
        ST_WALK: if (fire) begin
          if (rd_idx == psb_q) begin
            prev_q  <= cur_q;
            cl_q    <= mem_rdata_i;
            state_q <= ST_WR_PREV;
          end else begin
            cur_q <= rd_idx;
          end
        end
        ST_WR_PREV: if (fire)
          state_q <= src_null_q ? ST_RD_FLAGS : ST_RD_SRC2;
        ST_RD_SRC2: if (fire) begin
          word_q  <= mem_rdata_i;
          state_q <= (rd_idx == psb_q) ? ST_WR_SRC : ST_RD_DST;
        end
        ST_WR_SRC:   if (fire) state_q <= ST_RD_DST;
        ST_RD_FLAGS: if (fire) begin
          word_q  <= mem_rdata_i;
          state_q <= ST_WR_FLAGS;
        end
        ST_WR_FLAGS: if (fire) state_q <= ST_RD_DST;
        ST_RD_DST: if (fire) begin
          word_q <= mem_rdata_i;
          if (rd_idx == '0) begin
            dst_empty_q <= 1'b1;
            succ_q      <= psb_q;
            state_q     <= ST_WR_DST;
          end else begin
            dst_empty_q <= 1'b0;
            cur_q       <= rd_idx;
            state_q     <= ST_RD_TAIL;
          end
        end
        ST_RD_TAIL: if (fire) begin
          cl_q    <= mem_rdata_i;
          state_q <= rd_ge_psb ? ST_WR_DST : ST_RD_NEXT;
        end
        ST_WR_DST: if (fire)
          state_q <= dst_empty_q ? ST_WR_PSB : ST_WR_CUR;
        ST_RD_NEXT: if (fire) begin
          if (!rd_ge_psb) begin
            state_q <= ST_WR_CUR;
          end else begin
            cur_q <= cl_next;
            cl_q  <= mem_rdata_i;
          end
        end
        ST_WR_CUR: if (fire) begin
          succ_q  <= cl_next;
          state_q <= ST_WR_PSB;
        end
        ST_WR_PSB: if (fire) state_q <= ST_DONE;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/proc_q_chk.sv
module proc_q_chk
  import proc_q_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);

  assert_busy_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_no_idle_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || done_o) |-> !mem_req_o);
endmodule

bind proc_q_engine proc_q_chk #(.AW(AW)) u_proc_q_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/proc_q_engine_tb.sv
module proc_q_engine_tb;
  localparam int AW = 16;
  localparam time CYC = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_src_null = 1'b0;
  logic [AW-1:0] cmd_src = '0, cmd_dst = '0;
  logic [9:0]  cmd_idx = '0;
  logic        busy, done, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [0:1023];
  logic        slow = 1'b0, gate_q = 1'b0;
  int checks = 0, errors = 0;

  localparam int QA = 4, QB = 8, QC = 12, QD = 20;

  always #(CYC/2) clk = ~clk;

  proc_q_engine #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_src_null_i(cmd_src_null),
    .cmd_src_addr_i(cmd_src), .cmd_dst_addr_i(cmd_dst), .cmd_psb_idx_i(cmd_idx),
    .busy_o(busy), .done_o(done),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  assign mem_rdata = mem[mem_addr[9:0]];
  assign mem_ack   = mem_req && (!slow || gate_q);

  always @(posedge clk) begin
    gate_q <= ~gate_q;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[9:0]] = mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_link(input int prio, input int nxt);
    return 16'h8001 | 16'((prio & 7) << 12) | 16'((nxt & 10'h3ff) << 2);
  endfunction

  function automatic int nxt_of(input logic [15:0] w);
    return int'(w & 16'h0FFC);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[QA] = 16'hF001; mem[QB] = 16'hF001; mem[QC] = 16'hF001; mem[QD] = 16'hF001;
  endtask

  task automatic check_queue(input int qa, input int n, input int exp_q [8], input string tag);
    int t, p;
    t = nxt_of(mem[qa]);
    check((mem[qa] & 16'hF003) == 16'hF001, {tag, " R12 queue word bits"}, int'(mem[qa] & 16'hF003), 'hF001);
    if (n == 0) begin
      check(t == 0, {tag, " empty tail"}, t, 0);
    end else begin
      check(t == exp_q[n-1]*4, {tag, " tail"}, t, exp_q[n-1]*4);
      p = nxt_of(mem[t]);
      for (int i = 0; i < n; i++) begin
        check(p == exp_q[i]*4, {tag, " ring order"}, p, exp_q[i]*4);
        p = nxt_of(mem[p]);
      end
    end
  endtask

  task automatic run_cmd(input int idx, input bit snull, input int src, input int dst, input bit poke_busy);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src_null = snull; cmd_idx = 10'(idx);
    cmd_src = AW'(src); cmd_dst = AW'(dst);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
    if (poke_busy) begin
      // R1: a command while busy must be ignored
      cmd_valid = 1'b1; cmd_idx = 10'd20; cmd_src_null = 1'b1; cmd_dst = AW'(QC);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    check(done == 1'b1, "R2 done seen", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R2 done single pulse", int'(done), 0);
    check(busy == 1'b0, "R1 idle after done", int'(busy), 0);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(done == 1'b0, "R2 reset done", int'(done), 0);
    check(mem_req == 1'b0, "R4 reset no request", int'(mem_req), 0);
    repeat (3) @(negedge clk);
    check(mem_req == 1'b0, "R4 idle no request", int'(mem_req), 0);
  endtask

  task automatic t_mid_to_empty();
    clear_mem();
    mem[20*4] = mk_link(3, 21); mem[21*4] = mk_link(3, 22); mem[22*4] = mk_link(2, 20);
    mem[QA] = 16'hF001 | 16'(22*4);
    run_cmd(21, 1'b0, QA, QB, 1'b1);
    check_queue(QA, 2, '{20,22,0,0,0,0,0,0}, "R6 bypass middle");
    check_queue(QB, 1, '{21,0,0,0,0,0,0,0}, "R9 empty dst");
    check(mem[21*4] == mk_link(3, 21), "R12 moved link bits", int'(mem[21*4]), int'(mk_link(3, 21)));
    check(mem[QC] == 16'hF001, "R1 ignored command no effect", int'(mem[QC]), 'hF001);
  endtask

  task automatic t_tail_append();
    run_cmd(22, 1'b0, QA, QB, 1'b0);
    check_queue(QA, 1, '{20,0,0,0,0,0,0,0}, "R7 tail to predecessor");
    check_queue(QB, 2, '{21,22,0,0,0,0,0,0}, "R10 append lower prio");
    check(mem[20*4] == mk_link(3, 20), "R6 predecessor self link", int'(mem[20*4]), int'(mk_link(3, 20)));
  endtask

  task automatic t_self_ordered_slow();
    slow = 1'b1;
    run_cmd(20, 1'b0, QA, QB, 1'b0);
    slow = 1'b0;
    check_queue(QA, 0, '{0,0,0,0,0,0,0,0}, "R5 source emptied");
    check_queue(QB, 3, '{21,20,22,0,0,0,0,0}, "R11 FIFO among equals R3 waits");
  endtask

  task automatic t_null_src_head();
    mem[30*4] = mk_link(1, 31); mem[31*4] = mk_link(1, 30);
    mem[QC] = 16'hF001 | 16'(31*4);
    mem[32*4] = mk_link(6, 33); mem[33*4] = mk_link(1, 34); mem[34*4] = mk_link(4, 32);
    mem[32*4+1] = 16'hA003;
    run_cmd(32, 1'b1, 0, QC, 1'b0);
    check(mem[32*4+1] == (16'hA003 | 16'(33*4)), "R8 cleanup link", int'(mem[32*4+1]), int'(16'hA003 | 16'(33*4)));
    check(mem[34*4] == mk_link(4, 33), "R6 search from process", int'(mem[34*4]), int'(mk_link(4, 33)));
    check_queue(QC, 3, '{32,30,31,0,0,0,0,0}, "R11 new head");
  endtask

  task automatic t_null_equal_tail();
    run_cmd(33, 1'b1, 0, QC, 1'b0);
    check(mem[33*4+1] == 16'(34*4), "R8 cleanup next", int'(mem[33*4+1]), 34*4);
    check(mem[34*4] == mk_link(4, 34), "R6 ring bypass", int'(mem[34*4]), int'(mk_link(4, 34)));
    check_queue(QC, 4, '{32,30,31,33,0,0,0,0}, "R10 equal prio appended");
  endtask

  task automatic t_null_self();
    mem[40*4] = mk_link(5, 40); mem[40*4+1] = 16'h0000;
    run_cmd(40, 1'b1, 0, QD, 1'b0);
    check(mem[40*4+1] == 16'(40*4), "R8 cleanup self", int'(mem[40*4+1]), 40*4);
    check_queue(QD, 1, '{40,0,0,0,0,0,0,0}, "R9 empty dst self");
    check(mem[40*4] == mk_link(5, 40), "R12 link kept", int'(mem[40*4]), int'(mk_link(5, 40)));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CYC * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mid_to_empty();
    t_tail_append();
    t_self_ordered_slow();
    t_null_src_head();
    t_null_equal_tail();
    t_null_self();
    finish_run();
  end
endmodule